// File: doc/BRIEF.md
# Rank Chip-Select Matcher with Spare Substitution

This block resolves which rank of a memory channel owns a given channel address. Each channel holds eight chip-select base registers and four mask registers, with one mask shared by each pair of neighbouring chip selects. A lookup compares the upper part of the address against every enabled base. Bits that the shared mask sets are not compared. The lowest-numbered chip select that matches wins.

When online sparing has taken a failed rank out of service, a per-channel swap flag and a failed-rank number in a spare-control word redirect a lookup. A hit on the failed rank is answered with the lowest chip select of that channel whose base carries the spare flag. The result gives a found flag, the chip-select index and the DIMM index, which is the chip-select index halved. A simple write port loads all registers while the block is idle.

The lookup runs in a four-state machine:
- `ST_IDLE`: waits for a request; the register port is open.
- `ST_MATCH`: compares the address and picks the first hit.
- `ST_SUBST`: applies the spare redirect and registers the result.
- `ST_RESP`: presents the result for one cycle.

The transitions are:
- accept (`ST_IDLE`→`ST_MATCH`, on `req_valid`)
- compare (`ST_MATCH`→`ST_SUBST`)
- resolve (`ST_SUBST`→`ST_RESP`)
- release (`ST_RESP`→`ST_IDLE`)

Top module: `cs_rank_matcher`

## Requirements
- R1: After reset `ready` is 1 and `rsp_valid` is 0. Every base, mask and the spare-control word reset to zero, so any lookup misses.
- R2: A write (`wr_en` while `ready`) is decoded from `wr_addr` as follows:
  - If `wr_addr[5]` is 1, the write goes to the spare-control word.
  - Otherwise `wr_addr[4]` selects the channel.
  - With `wr_addr[3]`=0, the write loads the base of chip select `wr_addr[2:0]`.
  - With `wr_addr[3]`=1, the write loads mask register `wr_addr[1:0]`; `wr_addr[2]` is ignored.
- R3: Chip select n hits only when all of these hold:
  - Its base bit 0 (enable) is set.
  - `(req_addr[39:8] ^ base) & ~mask & 32'h1FF83FE0` is zero.
  
  Address bits [7:0] and all bits outside that constant are never compared. Base bit 1 alone does not enable a chip select.
- R4: Chip select n compares with mask register n>>1 of its own channel.
- R5: When several chip selects hit, the lowest index is reported.
- R6: A request is taken when `req_valid` and `ready` are both high. `ready` is then low until the result appears. `rsp_valid` is high for exactly one cycle, three clock edges after the accepting edge, and `ready` returns on the following cycle.
- R7: For channel c, the swap flag is spare-control bit 1+2c, and the failed-rank field is bits [6+4c:4+4c].
  - When the flag is set and the hit index equals the failed rank, the result becomes the lowest chip select of that channel whose base bit 1 is set.
  - If no such chip select exists, the hit index is kept.
- R8: `rsp_dimm` equals `rsp_cs` divided by two.
- R9: When no chip select hits, `rsp_found` is 0 and both `rsp_cs` and `rsp_dimm` are 0.
- R10: Register writes made while `ready` is low are dropped. A write made in the same cycle a request is accepted is used by that lookup.
- R11: Each channel uses only its own bases, masks, swap flag and failed-rank field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write address |
| wr_data | input | 32 | Register write data |
| req_valid | input | 1 | Lookup request |
| req_chan | input | 1 | Channel of the lookup |
| req_addr | input | 40 | Normalized channel address |
| ready | output | 1 | Idle; a request or write is accepted |
| rsp_valid | output | 1 | Result valid for one cycle |
| rsp_found | output | 1 | A chip select owns the address |
| rsp_cs | output | 3 | Chip-select index after spare redirect |
| rsp_dimm | output | 2 | DIMM index |

## Verification
The two functions that can meet in one cycle are a register write and the acceptance of a lookup. The bench provokes this by raising `wr_en` together with `req_valid`, writing the spare-control word. The result must reflect the new word. A second directed case writes while the lookup is in flight; it is judged by a later lookup, which must still see the old redirect. Random register contents, random mask pairs and addresses drawn near programmed bases are then compared against a bench model of priority, masking and spare substitution.

// File: rtl/cs_match_pkg.sv
package cs_match_pkg;

    // Lookup sequencer states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MATCH = 2'd1,
        ST_SUBST = 2'd2,
        ST_RESP  = 2'd3
    } lkp_state_e;

    // Address bits below this position never take part in a compare
    localparam int ALIGN_LSB = 8;

    // Spare-control field anchors: swap flag at SWAP_LSB + 2c, failed rank at BAD_LSB + 4c
    localparam int SWAP_LSB = 1;
    localparam int SWAP_STEP = 2;
    localparam int BAD_LSB = 4;
    localparam int BAD_STEP = 4;

endpackage

// File: rtl/cs_reg_bank.sv
module cs_reg_bank #(
    parameter int NUM_CHAN = 2,
    parameter int NUM_CS   = 8,
    parameter int REG_W    = 32,
    parameter int CS_W     = 3,
    parameter int CH_W     = 1,
    parameter int AW       = 6
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_allow,
    input  logic                            wr_en,
    input  logic [AW-1:0]                   wr_addr,
    input  logic [REG_W-1:0]                wr_data,
    input  logic [CH_W-1:0]                 rd_chan,
    output logic [NUM_CS-1:0][REG_W-1:0]    rd_bases,
    output logic [NUM_CS/2-1:0][REG_W-1:0]  rd_masks,
    output logic [REG_W-1:0]                spare_word
);

    localparam int PAIRS = NUM_CS / 2;

    logic [NUM_CS-1:0][REG_W-1:0] base_q [NUM_CHAN];
    logic [PAIRS-1:0][REG_W-1:0]  mask_q [NUM_CHAN];
    logic [REG_W-1:0]             spare_q;

    logic            wr_is_spare;
    logic            wr_is_mask;
    logic [CH_W-1:0] wr_chan;
    logic [CS_W-1:0] wr_cs;
    logic [CS_W-2:0] wr_pair;

    assign wr_is_spare = wr_addr[AW-1];
    assign wr_is_mask  = wr_addr[CS_W];
    assign wr_chan     = wr_addr[CS_W+1 +: CH_W];
    assign wr_cs       = wr_addr[CS_W-1:0];
    assign wr_pair     = wr_addr[CS_W-2:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_CHAN; c++) begin
                base_q[c] <= '0;
                mask_q[c] <= '0;
            end
            spare_q <= '0;
        end else if (wr_en && wr_allow) begin
            if (wr_is_spare) begin
                spare_q <= wr_data;
            end else if (!wr_is_mask) begin
                base_q[wr_chan][wr_cs] <= wr_data;
            end else begin
                mask_q[wr_chan][wr_pair] <= wr_data;
            end
        end
    end

    assign rd_bases   = base_q[rd_chan];
    assign rd_masks   = mask_q[rd_chan];
    assign spare_word = spare_q;

    AST_BUSY_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_allow |=> ($stable(spare_q) && $stable(rd_bases) && $stable(rd_masks))); // R10

    AST_SPARE_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_allow && wr_is_spare) |=> (spare_q == $past(wr_data))); // R2

endmodule

// File: rtl/cs_hit_vector.sv
module cs_hit_vector #(
    parameter int          NUM_CS   = 8,
    parameter int          REG_W    = 32,
    parameter logic [31:0] CMP_MASK = 32'h1FF8_3FE0
) (
    input  logic [REG_W-1:0]               key,
    input  logic [NUM_CS-1:0][REG_W-1:0]   bases,
    input  logic [NUM_CS/2-1:0][REG_W-1:0] masks,
    output logic [NUM_CS-1:0]              hit_vec,
    output logic [NUM_CS-1:0]              spare_vec
);

    localparam logic [REG_W-1:0] KEEP = REG_W'(CMP_MASK);

    for (genvar n = 0; n < NUM_CS; n++) begin : g_cs
        logic [REG_W-1:0] diff;
        assign diff         = (key ^ bases[n]) & ~masks[n/2] & KEEP;
        assign hit_vec[n]   = bases[n][0] && (diff == '0);
        assign spare_vec[n] = bases[n][1];
    end

endmodule

// File: rtl/cs_first_pick.sv
module cs_first_pick #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx
);

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = IW'(i);
            end
        end
        any = |vec;
    end

endmodule

// File: rtl/cs_rank_matcher.sv
module cs_rank_matcher
    import cs_match_pkg::*;
#(
    parameter int          NUM_CHAN = 2,
    parameter int          NUM_CS   = 8,
    parameter int          REG_W    = 32,
    parameter logic [31:0] CMP_MASK = 32'h1FF8_3FE0,
    localparam int         CS_W     = $clog2(NUM_CS),
    localparam int         CH_W     = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1,
    localparam int         AW       = CH_W + CS_W + 2,
    localparam int         ADDR_W   = REG_W + ALIGN_LSB,
    localparam int         DIMM_W   = CS_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              req_valid,
    input  logic [CH_W-1:0]   req_chan,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              ready,
    output logic              rsp_valid,
    output logic              rsp_found,
    output logic [CS_W-1:0]   rsp_cs,
    output logic [DIMM_W-1:0] rsp_dimm
);

    lkp_state_e state_q, state_d;

    logic [CH_W-1:0]  chan_q;
    logic [REG_W-1:0] key_q;
    logic             hit_any_q;
    logic [CS_W-1:0]  hit_idx_q;
    logic             found_q;
    logic [CS_W-1:0]  cs_q;

    logic [NUM_CS-1:0][REG_W-1:0]   cur_bases;
    logic [NUM_CS/2-1:0][REG_W-1:0] cur_masks;
    logic [REG_W-1:0]               spare_word;
    logic [NUM_CS-1:0]              hit_vec;
    logic [NUM_CS-1:0]              spare_vec;
    logic                           pick_any;
    logic [CS_W-1:0]                pick_idx;
    logic                           spare_any;
    logic [CS_W-1:0]                spare_idx;
    logic [NUM_CHAN-1:0]            swap_by_chan;
    logic [NUM_CHAN-1:0][CS_W-1:0]  bad_by_chan;
    logic                           redirect;

    // ---------------- register storage ----------------
    cs_reg_bank #(
        .NUM_CHAN (NUM_CHAN),
        .NUM_CS   (NUM_CS),
        .REG_W    (REG_W),
        .CS_W     (CS_W),
        .CH_W     (CH_W),
        .AW       (AW)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_allow   (ready),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_chan    (chan_q),
        .rd_bases   (cur_bases),
        .rd_masks   (cur_masks),
        .spare_word (spare_word)
    );

    // ---------------- compare and priority ----------------
    cs_hit_vector #(
        .NUM_CS   (NUM_CS),
        .REG_W    (REG_W),
        .CMP_MASK (CMP_MASK)
    ) u_hits (
        .key       (key_q),
        .bases     (cur_bases),
        .masks     (cur_masks),
        .hit_vec   (hit_vec),
        .spare_vec (spare_vec)
    );

    cs_first_pick #(.N(NUM_CS), .IW(CS_W)) u_pick_hit (
        .vec (hit_vec),
        .any (pick_any),
        .idx (pick_idx)
    );

    cs_first_pick #(.N(NUM_CS), .IW(CS_W)) u_pick_spare (
        .vec (spare_vec),
        .any (spare_any),
        .idx (spare_idx)
    );

    // ---------------- per-channel spare-control fields ----------------
    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_spare_fields
        assign swap_by_chan[c] = spare_word[SWAP_LSB + SWAP_STEP * c];
        assign bad_by_chan[c]  = spare_word[BAD_LSB + BAD_STEP * c +: CS_W];
    end

    assign redirect = hit_any_q && swap_by_chan[chan_q]
                      && (hit_idx_q == bad_by_chan[chan_q]) && spare_any;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_MATCH;
            ST_MATCH: state_d = ST_SUBST;
            ST_SUBST: state_d = ST_RESP;
            ST_RESP:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_q    <= '0;
            key_q     <= '0;
            hit_any_q <= 1'b0;
            hit_idx_q <= '0;
            found_q   <= 1'b0;
            cs_q      <= '0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                chan_q <= req_chan;
                key_q  <= req_addr[ALIGN_LSB +: REG_W];
            end
            if (state_q == ST_MATCH) begin
                hit_any_q <= pick_any;
                hit_idx_q <= pick_idx;
            end
            if (state_q == ST_SUBST) begin
                found_q <= hit_any_q;
                if (!hit_any_q) begin
                    cs_q <= '0;
                end else if (redirect) begin
                    cs_q <= spare_idx;
                end else begin
                    cs_q <= hit_idx_q;
                end
            end
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        ready     = (state_q == ST_IDLE);
        rsp_valid = (state_q == ST_RESP);
        rsp_found = found_q;
        rsp_cs    = cs_q;
        rsp_dimm  = cs_q[CS_W-1:1];
    end

    // ---------------- assertions ----------------
    AST_RSP_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R6

    AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(ready && req_valid, 3)); // R6

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req_valid) |=> !ready); // R6

    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_found) |-> (rsp_cs == '0 && rsp_dimm == '0)); // R9

    AST_FOUND_IS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_found) |-> (cur_bases[rsp_cs][0] || cur_bases[rsp_cs][1])); // R3

    AST_REDIRECT_TO_SPARE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SUBST && redirect) |=> cur_bases[rsp_cs][1]); // R7

endmodule

// File: tb/test_cs_rank_matcher.sv
`timescale 1ns/1ps
module test_cs_rank_matcher;

    localparam logic [31:0] KEEP = 32'h1FF8_3FE0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        req_valid = 1'b0;
    logic [0:0]  req_chan = '0;
    logic [39:0] req_addr = '0;
    logic        ready, rsp_valid, rsp_found;
    logic [2:0]  rsp_cs;
    logic [1:0]  rsp_dimm;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] mb [2][8];
    logic [31:0] mm [2][4];
    logic [31:0] ms;

    always #2.5 clk = ~clk;

    cs_rank_matcher i_cs_rank_matcher (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .req_valid(req_valid), .req_chan(req_chan), .req_addr(req_addr),
        .ready(ready), .rsp_valid(rsp_valid), .rsp_found(rsp_found),
        .rsp_cs(rsp_cs), .rsp_dimm(rsp_dimm)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] a_base(input int ch, input int n);
        return {1'b0, 1'(ch), 1'b0, 3'(n)};
    endfunction

    function automatic logic [5:0] a_mask(input int ch, input int p);
        return {1'b0, 1'(ch), 2'b10, 2'(p)};
    endfunction

    localparam logic [5:0] A_SPARE = 6'h20;

    // R2 register map as seen by the bench
    function automatic void model_write(input logic [5:0] wa, input logic [31:0] wd);
        if (wa[5]) ms = wd;
        else if (!wa[3]) mb[wa[4]][wa[2:0]] = wd;
        else mm[wa[4]][wa[1:0]] = wd;
    endfunction

    // {found, cs} from R3, R4, R5, R7, R9, R11
    function automatic logic [3:0] model(input int ch, input logic [31:0] key);
        logic       f = 1'b0;
        logic [2:0] cs = '0;
        logic       swp;
        logic [2:0] bad;
        for (int n = 7; n >= 0; n--) begin
            if (mb[ch][n][0] && (((key ^ mb[ch][n]) & ~mm[ch][n/2] & KEEP) == 0)) begin
                f = 1'b1;
                cs = 3'(n);
            end
        end
        swp = ms[1 + 2*ch];
        bad = ms[4 + 4*ch +: 3];
        if (f && swp && cs == bad) begin
            for (int n = 7; n >= 0; n--) begin
                if (mb[ch][n][1]) cs = 3'(n);
            end
        end
        return {f, cs};
    endfunction

    task automatic wait_ready();
        while (!ready) @(negedge clk);
    endtask

    task automatic reg_write(input logic [5:0] wa, input logic [31:0] wd);
        wait_ready();
        wr_en = 1'b1; wr_addr = wa; wr_data = wd;
        model_write(wa, wd);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic lookup(input int ch, input logic [31:0] key, input string tag,
                          input bit same_wr = 1'b0, input logic [5:0] wa = '0,
                          input logic [31:0] wd = '0, input bit busy_wr = 1'b0,
                          input bit timing = 1'b0);
        logic [3:0] e;
        wait_ready();
        req_valid = 1'b1; req_chan = 1'(ch); req_addr = {key, 8'h5A};
        if (same_wr) begin
            wr_en = 1'b1; wr_addr = wa; wr_data = wd;
            model_write(wa, wd);
        end
        e = model(ch, key);
        @(negedge clk);
        req_valid = 1'b0; wr_en = 1'b0;
        if (timing) check("R6 ready low after accept", ready, 1'b0);
        if (busy_wr) begin
            wr_en = 1'b1; wr_addr = wa; wr_data = wd;
        end
        @(negedge clk);
        wr_en = 1'b0;
        if (timing) check("R6 no early response", rsp_valid, 1'b0);
        @(negedge clk);
        check({tag, " rsp_valid"}, rsp_valid, 1'b1);
        check({tag, " found/cs"}, {rsp_found, rsp_cs}, e);
        check("R8 dimm index", rsp_dimm, e[2:1]);
        @(negedge clk);
        if (timing) begin
            check("R6 single-cycle response", rsp_valid, 1'b0);
            check("R6 ready returns", ready, 1'b1);
        end
    endtask

    task automatic random_config();
        for (int c = 0; c < 2; c++) begin
            for (int n = 0; n < 8; n++) begin
                logic [31:0] b = $urandom;
                if (n > 0 && ($urandom % 4) == 0) b = mb[c][n-1];
                b[0] = (($urandom % 4) != 0);
                b[1] = (($urandom % 6) == 0);
                reg_write(a_base(c, n), b);
            end
            for (int p = 0; p < 4; p++) reg_write(a_mask(c, p), $urandom & 32'h0003_03E0);
        end
        reg_write(A_SPARE, $urandom & 32'h0000_07FF);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd20241));
        for (int c = 0; c < 2; c++) begin
            for (int n = 0; n < 8; n++) mb[c][n] = '0;
            for (int p = 0; p < 4; p++) mm[c][p] = '0;
        end
        ms = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready after reset", ready, 1'b1);
        check("R1 no response after reset", rsp_valid, 1'b0);
        lookup(0, 32'h0010_0000, "R1 R9 empty tables miss", 1'b0, '0, '0, 1'b0, 1'b1);

        // R2 R3 basic match, compared and ignored bits
        reg_write(a_base(0, 2), 32'h0010_0001);
        lookup(0, 32'h0010_0000, "R3 exact hit");
        lookup(0, 32'h0010_0020, "R3 R9 compared bit differs");
        lookup(0, 32'h0010_0004, "R3 bit outside compare mask ignored");

        // R4 shared masks
        reg_write(a_mask(0, 1), 32'h0000_0020);
        lookup(0, 32'h0010_0020, "R4 mask pair1 on cs2");
        reg_write(a_base(0, 3), 32'h0020_0001);
        lookup(0, 32'h0020_0020, "R4 mask pair1 on cs3");
        reg_write(a_base(0, 4), 32'h0030_0001);
        lookup(0, 32'h0030_0020, "R4 pair2 mask not shared");

        // R5 priority
        reg_write(a_base(0, 6), 32'h0010_0001);
        reg_write(a_base(0, 1), 32'h0010_0001);
        lookup(0, 32'h0010_0000, "R5 lowest of cs1 cs2 cs6");
        reg_write(a_base(0, 1), 32'h0010_0000);
        lookup(0, 32'h0010_0000, "R5 disabled cs1 skipped");

        // R11 channel separation
        lookup(1, 32'h0010_0000, "R11 channel1 empty");
        reg_write(a_base(1, 5), 32'h0010_0001);
        lookup(1, 32'h0010_0000, "R11 channel1 own base");

        // R7 spare substitution
        reg_write(a_base(0, 7), 32'h0F00_0003);
        reg_write(a_base(0, 5), 32'h0F00_0002);
        lookup(0, 32'h0F00_0000, "R3 spare-only cs not enabled");
        reg_write(A_SPARE, 32'h0000_0022);
        lookup(0, 32'h0010_0000, "R7 failed rank redirected");
        lookup(0, 32'h0030_0000, "R7 other rank untouched");
        lookup(1, 32'h0010_0000, "R11 channel0 swap ignored on channel1");
        reg_write(A_SPARE, 32'h0000_052A);
        lookup(1, 32'h0010_0000, "R7 no spare marked keeps rank");
        reg_write(a_base(1, 0), 32'h0000_0002);
        lookup(1, 32'h0010_0000, "R7 channel1 redirect");

        // R10 write during busy dropped, then same-cycle write used
        lookup(0, 32'h0010_0000, "R10 busy write", 1'b0, A_SPARE, 32'h0, 1'b1);
        lookup(0, 32'h0010_0000, "R10 busy write dropped");
        lookup(0, 32'h0010_0000, "R10 same-cycle write used", 1'b1, A_SPARE, 32'h0);

        // random phase: R3 R4 R5 R7 R8 R9 R11
        for (int k = 0; k < 300; k++) begin
            if (k % 25 == 0) random_config();
            begin
                int ch = int'($urandom % 2);
                int n  = int'($urandom % 8);
                logic [31:0] key = mb[ch][n] ^ ($urandom & mm[ch][n/2]);
                if (($urandom % 4) == 0) key = key ^ (32'h1 << ($urandom % 32));
                lookup(ch, key, "R5 R7 random lookup");
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule